// File: doc/BRIEF.md
# Doorbell Interrupt Register Pair

This block carries event flags in both directions between a remote host and a local processor core. It holds two doorbell words. The inbound word is raised by the host and interrupts the core. The outbound word is raised by the core and pulls an active-low interrupt line toward the host. Each side raises flags by writing ones to the word it owns on the raising side. Only the opposite side can lower those flags, also by writing ones. A one-bit mask per direction silences each interrupt output without touching the pending flags.

Each side has its own write port and its own read port. Both ports see the same four-word map. Word 0 is the inbound doorbell and word 1 is the outbound doorbell. Word 2 holds the inbound mask in bit 0, and word 3 holds the outbound mask in bit 0. The interrupt outputs and the read data are registered.

Top module: `dbell_pair`

## Requirements
- R1: While `rst` is high and on the first cycle after it, both doorbell words and both masks read zero, `core_irq` is 0, `inta_n` is 1, and both read data buses are zero.
- R2: A host write to word 0 sets every inbound bit whose `host_wdata` bit is one, and leaves all other inbound bits unchanged.
- R3: A core write to word 0 clears every inbound bit whose `core_wdata` bit is one. No host write clears an inbound bit.
- R4: A core write to word 1 sets every outbound bit whose `core_wdata` bit is one, and leaves all other outbound bits unchanged.
- R5: A host write to word 1 clears every outbound bit whose `host_wdata` bit is one, and writing zero to a bit has no effect. No core write clears an outbound bit.
- R6: On each clock edge, `core_irq` becomes 1 exactly when the inbound word held before that edge was nonzero and the inbound mask was 0.
- R7: On each clock edge, `inta_n` becomes 0 exactly when the outbound word held before that edge was nonzero and the outbound mask was 0.
- R8: The inbound mask is written only by a core write to word 2, and the outbound mask only by a host write to word 3; bit 0 of the write data is stored. A mask write never changes either doorbell word. Host writes to word 2 and core writes to word 3 are ignored.
- R9: If the same inbound or outbound bit is set and cleared in the same cycle, the bit ends up set.
- R10: Each read port returns, one cycle after the edge at which it samples its address, the addressed word as it stood before any write taken at that same edge. Words 2 and 3 return their mask in bit 0 and zero in every other bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host write strobe |
| host_waddr | input | 2 | Host write word select |
| host_wdata | input | W | Host write data |
| host_raddr | input | 2 | Host read word select |
| host_rdata | output | W | Host read data, registered |
| core_we | input | 1 | Core write strobe |
| core_waddr | input | 2 | Core write word select |
| core_wdata | input | W | Core write data |
| core_raddr | input | 2 | Core read word select |
| core_rdata | output | W | Core read data, registered |
| core_irq | output | 1 | Interrupt to local core, active high |
| inta_n | output | 1 | Interrupt to host, active low |

## Verification
A flag lost or falsely raised in either doorbell word reaches the interrupt pins one edge after the state goes wrong. The same flag reaches a read port one edge after its address is sampled, so the reference model, compared on every clock, catches it within two cycles. A mask that takes a write from the wrong side shows up at once as an interrupt pin that disagrees with the model. A clear that wins over a same-cycle set leaves a zero bit in the read-back where the model holds a one.

// File: rtl/dbell_pkg.sv
package dbell_pkg;
  localparam int unsigned ADDR_W = 2;
  localparam logic [ADDR_W-1:0] WORD_IN     = 2'd0;
  localparam logic [ADDR_W-1:0] WORD_OUT    = 2'd1;
  localparam logic [ADDR_W-1:0] WORD_IN_MSK = 2'd2;
  localparam logic [ADDR_W-1:0] WORD_OUT_MSK = 2'd3;
endpackage

// File: rtl/dbell_word.sv
// One doorbell word: per-bit set and clear, set has priority.
module dbell_word #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_vec,
  input  logic [W-1:0] clr_vec,
  output logic [W-1:0] q
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)              q[b] <= 1'b0;
      else if (set_vec[b])  q[b] <= 1'b1;
      else if (clr_vec[b])  q[b] <= 1'b0;
    end
  end
endmodule

// File: rtl/dbell_irq.sv
// Mask flop plus registered interrupt output of selectable polarity.
module dbell_irq #(
  parameter bit ACTIVE_LOW = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic pend_any,
  input  logic msk_we,
  input  logic msk_d,
  output logic msk_q,
  output logic irq_o
);
  logic fire;
  assign fire = pend_any && !msk_q;

  always_ff @(posedge clk) begin
    if (rst)         msk_q <= 1'b0;
    else if (msk_we) msk_q <= msk_d;
  end

  if (ACTIVE_LOW) begin : g_low
    always_ff @(posedge clk) begin
      if (rst) irq_o <= 1'b1;
      else     irq_o <= !fire;
    end
  end else begin : g_high
    always_ff @(posedge clk) begin
      if (rst) irq_o <= 1'b0;
      else     irq_o <= fire;
    end
  end
endmodule

// File: rtl/dbell_rport.sv
// Registered read port over the four-word map.
module dbell_rport
  import dbell_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] raddr,
  input  logic [W-1:0]      in_db,
  input  logic [W-1:0]      out_db,
  input  logic              in_msk,
  input  logic              out_msk,
  output logic [W-1:0]      rdata
);
  logic [W-1:0] sel;

  always_comb begin
    sel = '0;
    case (raddr)
      WORD_IN:      sel = in_db;
      WORD_OUT:     sel = out_db;
      WORD_IN_MSK:  sel[0] = in_msk;
      default:      sel[0] = out_msk;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= sel;
  end
endmodule

// File: rtl/dbell_pair.sv
module dbell_pair
  import dbell_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_waddr,
  input  logic [W-1:0]      host_wdata,
  input  logic [ADDR_W-1:0] host_raddr,
  output logic [W-1:0]      host_rdata,
  input  logic              core_we,
  input  logic [ADDR_W-1:0] core_waddr,
  input  logic [W-1:0]      core_wdata,
  input  logic [ADDR_W-1:0] core_raddr,
  output logic [W-1:0]      core_rdata,
  output logic              core_irq,
  output logic              inta_n
);
  logic [W-1:0] in_db, out_db;
  logic [W-1:0] in_set, in_clr, out_set, out_clr;
  logic         in_msk, out_msk;

  // Inbound: host raises, core lowers. Outbound: the reverse.
  assign in_set  = (host_we && host_waddr == WORD_IN)  ? host_wdata : '0;
  assign in_clr  = (core_we && core_waddr == WORD_IN)  ? core_wdata : '0;
  assign out_set = (core_we && core_waddr == WORD_OUT) ? core_wdata : '0;
  assign out_clr = (host_we && host_waddr == WORD_OUT) ? host_wdata : '0;

  dbell_word #(.W(W)) u_in (
    .clk(clk), .rst(rst), .set_vec(in_set), .clr_vec(in_clr), .q(in_db)
  );
  dbell_word #(.W(W)) u_out (
    .clk(clk), .rst(rst), .set_vec(out_set), .clr_vec(out_clr), .q(out_db)
  );

  dbell_irq #(.ACTIVE_LOW(1'b0)) u_irq_core (
    .clk(clk), .rst(rst), .pend_any(|in_db),
    .msk_we(core_we && core_waddr == WORD_IN_MSK), .msk_d(core_wdata[0]),
    .msk_q(in_msk), .irq_o(core_irq)
  );
  dbell_irq #(.ACTIVE_LOW(1'b1)) u_irq_host (
    .clk(clk), .rst(rst), .pend_any(|out_db),
    .msk_we(host_we && host_waddr == WORD_OUT_MSK), .msk_d(host_wdata[0]),
    .msk_q(out_msk), .irq_o(inta_n)
  );

  dbell_rport #(.W(W)) u_rd_host (
    .clk(clk), .rst(rst), .raddr(host_raddr), .in_db(in_db), .out_db(out_db),
    .in_msk(in_msk), .out_msk(out_msk), .rdata(host_rdata)
  );
  dbell_rport #(.W(W)) u_rd_core (
    .clk(clk), .rst(rst), .raddr(core_raddr), .in_db(in_db), .out_db(out_db),
    .in_msk(in_msk), .out_msk(out_msk), .rdata(core_rdata)
  );
endmodule

// File: rtl/dbell_pair_chk.sv
module dbell_pair_chk
  import dbell_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              host_we,
  input logic [ADDR_W-1:0] host_waddr,
  input logic [W-1:0]      host_wdata,
  input logic              core_we,
  input logic [ADDR_W-1:0] core_waddr,
  input logic [W-1:0]      core_wdata,
  input logic [W-1:0]      in_db,
  input logic [W-1:0]      out_db,
  input logic              in_msk,
  input logic              out_msk,
  input logic              core_irq,
  input logic              inta_n
);
  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (in_db == '0 && out_db == '0 && !in_msk && !out_msk && !core_irq && inta_n)); // R1
  AST_HOST_SETS_IN: assert property (@(posedge clk) disable iff (rst)
    (host_we && host_waddr == WORD_IN) |=> ((in_db & $past(host_wdata)) == $past(host_wdata))); // R2
  AST_IN_NO_HOST_CLR: assert property (@(posedge clk) disable iff (rst)
    !(core_we && core_waddr == WORD_IN) |=> ((in_db & $past(in_db)) == $past(in_db))); // R3
  AST_CORE_SETS_OUT: assert property (@(posedge clk) disable iff (rst)
    (core_we && core_waddr == WORD_OUT) |=> ((out_db & $past(core_wdata)) == $past(core_wdata))); // R4
  AST_OUT_NO_CORE_CLR: assert property (@(posedge clk) disable iff (rst)
    !(host_we && host_waddr == WORD_OUT) |=> ((out_db & $past(out_db)) == $past(out_db))); // R5
  AST_CORE_IRQ_LEVEL: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (core_irq == ($past(|in_db) && !$past(in_msk)))); // R6
  AST_INTA_LEVEL: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (inta_n == !($past(|out_db) && !$past(out_msk)))); // R7
  AST_IN_MSK_OWNER: assert property (@(posedge clk) disable iff (rst)
    !(core_we && core_waddr == WORD_IN_MSK) |=> $stable(in_msk)); // R8
  AST_OUT_MSK_OWNER: assert property (@(posedge clk) disable iff (rst)
    !(host_we && host_waddr == WORD_OUT_MSK) |=> $stable(out_msk)); // R8
  AST_SET_WINS_OUT: assert property (@(posedge clk) disable iff (rst)
    (core_we && core_waddr == WORD_OUT && host_we && host_waddr == WORD_OUT)
      |=> ((out_db & $past(core_wdata)) == $past(core_wdata))); // R9
endmodule

bind dbell_pair dbell_pair_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst),
  .host_we(host_we), .host_waddr(host_waddr), .host_wdata(host_wdata),
  .core_we(core_we), .core_waddr(core_waddr), .core_wdata(core_wdata),
  .in_db(in_db), .out_db(out_db), .in_msk(in_msk), .out_msk(out_msk),
  .core_irq(core_irq), .inta_n(inta_n)
);

// File: tb/sim_dbell_pair.sv
`timescale 1ns/1ps
module sim_dbell_pair;
  localparam int W = 32;
  logic clk = 1'b0, rst = 1'b1;
  logic host_we = 1'b0, core_we = 1'b0;
  logic [1:0] host_waddr = '0, core_waddr = '0, host_raddr = '0, core_raddr = '0;
  logic [W-1:0] host_wdata = '0, core_wdata = '0;
  logic [W-1:0] host_rdata, core_rdata;
  logic core_irq, inta_n;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk; // 250 MHz

  dbell_pair #(.W(W)) u0 (
    .clk(clk), .rst(rst),
    .host_we(host_we), .host_waddr(host_waddr), .host_wdata(host_wdata),
    .host_raddr(host_raddr), .host_rdata(host_rdata),
    .core_we(core_we), .core_waddr(core_waddr), .core_wdata(core_wdata),
    .core_raddr(core_raddr), .core_rdata(core_rdata),
    .core_irq(core_irq), .inta_n(inta_n)
  );

  // Behavioural reference model
  logic [W-1:0] m_in = '0, m_out = '0, m_hrd = '0, m_crd = '0;
  logic m_inmsk = 0, m_outmsk = 0, m_irq = 0, m_inta_n = 1;

  function automatic logic [W-1:0] view(input logic [1:0] a);
    case (a)
      2'd0: return m_in;
      2'd1: return m_out;
      2'd2: return {{(W-1){1'b0}}, m_inmsk};
      default: return {{(W-1){1'b0}}, m_outmsk};
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_in <= '0; m_out <= '0; m_inmsk <= 0; m_outmsk <= 0;
      m_irq <= 0; m_inta_n <= 1; m_hrd <= '0; m_crd <= '0;
    end else begin
      logic [W-1:0] s_in, c_in, s_out, c_out;
      s_in  = (host_we && host_waddr == 0) ? host_wdata : '0;
      c_in  = (core_we && core_waddr == 0) ? core_wdata : '0;
      s_out = (core_we && core_waddr == 1) ? core_wdata : '0;
      c_out = (host_we && host_waddr == 1) ? host_wdata : '0;
      m_in  <= (m_in & ~c_in) | s_in;
      m_out <= (m_out & ~c_out) | s_out;
      if (core_we && core_waddr == 2) m_inmsk <= core_wdata[0];
      if (host_we && host_waddr == 3) m_outmsk <= host_wdata[0];
      m_irq    <= (m_in != 0) && !m_inmsk;
      m_inta_n <= !((m_out != 0) && !m_outmsk);
      m_hrd <= view(host_raddr);
      m_crd <= view(core_raddr);
    end
  end

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // Per-clock comparison against the model, away from the active edge
  always @(negedge clk) if (!rst && !done) begin
    chk("R6 core_irq vs model", {{(W-1){1'b0}}, core_irq}, {{(W-1){1'b0}}, m_irq});
    chk("R7 inta_n vs model", {{(W-1){1'b0}}, inta_n}, {{(W-1){1'b0}}, m_inta_n});
    chk("R10 host_rdata vs model", host_rdata, m_hrd);
    chk("R10 core_rdata vs model", core_rdata, m_crd);
  end

  task automatic hwr(input logic [1:0] a, input logic [W-1:0] d);
    host_we = 1; host_waddr = a; host_wdata = d;
    @(negedge clk); host_we = 0;
  endtask
  task automatic cwr(input logic [1:0] a, input logic [W-1:0] d);
    core_we = 1; core_waddr = a; core_wdata = d;
    @(negedge clk); core_we = 0;
  endtask
  task automatic rd(input string tag, input logic [1:0] a, input logic [W-1:0] exp);
    host_raddr = a; core_raddr = a;
    @(negedge clk);
    chk(tag, host_rdata, exp);
    chk(tag, core_rdata, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 core_irq in reset", {31'd0, core_irq}, 32'd0);
    chk("R1 inta_n in reset", {31'd0, inta_n}, 32'd1);
    chk("R1 host_rdata in reset", host_rdata, 32'd0);
    rst = 0;
    rd("R1 inbound after reset", 2'd0, 32'd0);
    rd("R1 outbound after reset", 2'd1, 32'd0);

    hwr(2'd0, 32'h0000_00A5);
    rd("R2 host sets inbound", 2'd0, 32'h0000_00A5);
    chk("R6 core_irq raised", {31'd0, core_irq}, 32'd1);
    hwr(2'd0, 32'h0000_0000);
    rd("R3 host zero write no clear", 2'd0, 32'h0000_00A5);
    cwr(2'd0, 32'h0000_0005);
    rd("R3 core clears inbound", 2'd0, 32'h0000_00A0);

    cwr(2'd1, 32'h8001_0000);
    rd("R4 core sets outbound", 2'd1, 32'h8001_0000);
    chk("R7 inta_n asserted", {31'd0, inta_n}, 32'd0);
    cwr(2'd1, 32'h0000_0000);
    rd("R5 core cannot clear outbound", 2'd1, 32'h8001_0000);
    hwr(2'd1, 32'h0001_0000);
    rd("R5 host clears outbound", 2'd1, 32'h8000_0000);

    hwr(2'd3, 32'h1);
    rd("R8 outbound mask set", 2'd3, 32'h1);
    chk("R8 inta_n masked", {31'd0, inta_n}, 32'd1);
    rd("R8 outbound kept under mask", 2'd1, 32'h8000_0000);
    cwr(2'd3, 32'h0);
    rd("R8 core write to out mask ignored", 2'd3, 32'h1);
    cwr(2'd2, 32'hFFFF_FFFF);
    rd("R8 inbound mask bit0 only", 2'd2, 32'h1);
    chk("R8 core_irq masked", {31'd0, core_irq}, 32'd0);
    hwr(2'd2, 32'h0);
    rd("R8 host write to in mask ignored", 2'd2, 32'h1);

    host_we = 1; host_waddr = 2'd0; host_wdata = 32'h8;
    core_we = 1; core_waddr = 2'd0; core_wdata = 32'h8;
    @(negedge clk); host_we = 0; core_we = 0;
    rd("R9 inbound set wins", 2'd0, 32'h0000_00A8);
    host_we = 1; host_waddr = 2'd1; host_wdata = 32'h8000_0000;
    core_we = 1; core_waddr = 2'd1; core_wdata = 32'h8000_0000;
    @(negedge clk); host_we = 0; core_we = 0;
    rd("R9 outbound set wins", 2'd1, 32'h8000_0000);

    // R10: read and write of the same word in one cycle returns the old value
    host_raddr = 2'd0; core_raddr = 2'd0;
    hwr(2'd0, 32'h0100_0000);
    chk("R10 read before same-edge write", host_rdata, 32'h0000_00A8);

    for (int i = 0; i < 2000; i++) begin
      host_we = 1'($urandom); host_waddr = 2'($urandom);
      host_wdata = (($urandom % 4) == 0) ? 32'hFFFF_FFFF : $urandom & $urandom;
      core_we = 1'($urandom); core_waddr = 2'($urandom);
      core_wdata = (($urandom % 4) == 0) ? 32'hFFFF_FFFF : $urandom & $urandom;
      host_raddr = 2'($urandom); core_raddr = 2'($urandom);
      @(negedge clk);
    end
    host_we = 0; core_we = 0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule